// File: doc/BRIEF.md
# Supply Voltage Health Monitor

This block watches three supply rails through six undervoltage comparator flags. Each rail has one flag for 5% low and one for 10% low. It reduces them to one health state: normal, coping or failed. It measures how long each fault condition lasts by counting millisecond ticks. A coping condition that lasts long enough raises a one-cycle non-maskable interrupt. If it lasts longer still, it sets a sticky functional status bit, which is cleared by writing one to it.

A rail that stays 10% low for too long moves the block into the failed state. In that state it drops the enables of two downstream DC-DC converters. Only a reset, the equivalent of a power cycle, brings the block out of failed.

Each raw comparator flag first passes through a synchroniser. It is then debounced: a short pulse never reaches the timers.

Top module: `supplyHealthMon`

## Requirements
- R1: A comparator flag counts as active only after it has passed a SYNC_STAGES-flop synchroniser and then kept its new value for STABLE_CYCLES consecutive clocks. A pulse of fewer than STABLE_CYCLES clocks has no effect on state, timers, interrupt or status.
- R2: The state output is encoded as 2'b00 normal, 2'b01 coping and 2'b10 failed. 2'b11 never appears. Outside failed, the state is coping when any filtered flag (5% low or 10% low, any rail) is active, and normal otherwise.
- R3: The coping timer counts msTick pulses while the coping condition holds. It clears as soon as the condition goes away, so a broken episode restarts from zero.
- R4: nmiPulse is high for exactly one clock, on the edge that samples the NMI_MS-th tick of a coping episode. It fires once per episode.
- R5: funcStatus sets on the edge that samples the STATUS_MS-th tick of a coping episode. It stays set until a statusClr pulse clears it. A set in the same cycle wins over a clear.
- R6: A separate timer counts ticks while any 10%-low flag is active, and it clears when none is active. The state becomes failed on the edge that samples its FAIL_MS-th tick.
- R7: convEnA and convEnB are 1 from reset. Both drop to 0 on the same edge that enters failed.
- R8: Failed is permanent until rstN. After it, no flag or tick changes the state or the enables, and no further nmiPulse is raised.
- R9: Reset gives state 2'b00, nmiPulse 0, funcStatus 0, and both enables 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power cycle) |
| lowWarnRaw | input | NUM_RAILS | Per-rail 5%-low comparator flags, asynchronous |
| lowCritRaw | input | NUM_RAILS | Per-rail 10%-low comparator flags, asynchronous |
| msTick | input | 1 | One-clock pulse per millisecond |
| statusClr | input | 1 | Write-one-to-clear strobe for funcStatus |
| healthState | output | 2 | 00 normal, 01 coping, 10 failed |
| nmiPulse | output | 1 | One-cycle non-maskable interrupt |
| funcStatus | output | 1 | Sticky long-coping status bit |
| convEnA | output | 1 | Enable of the first converter |
| convEnB | output | 1 | Enable of the second converter |

## Verification
The bench builds the block with NMI_MS=3, STATUS_MS=7 and FAIL_MS=4, with the default filter of two sync stages and four stable clocks. With these values the interrupt, the status set and the converter shutdown each happen within a handful of ticks. Ticks are spaced 16 clocks apart, so hundreds of episodes fit in a short run. The short 10%-low limit lets both orders be reached: a critical episode that is broken just before failing, and one that fails. After the failure, random flags check that the latched state really is frozen.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    HS_NORMAL = 2'b00,
    HS_COPING = 2'b01,
    HS_FAILED = 2'b10
  } healthE;

  // datapath -> control strobes
  typedef struct packed {
    logic copeCond;
    logic nmiHit;
    logic statHit;
    logic failHit;
  } dpStrobeT;

  // control -> datapath strobes
  typedef struct packed {
    logic freeze;
  } ctrlStrobeT;
endpackage

// File: rtl/shmDatapath.sv
module shmDatapath
  import shm_pkg::*;
#(
  parameter int NUM_RAILS     = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4,
  parameter int NMI_MS        = 100,
  parameter int STATUS_MS     = 500,
  parameter int FAIL_MS       = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RAILS-1:0] warnRaw,
  input  logic [NUM_RAILS-1:0] critRaw,
  input  logic                 msTick,
  input  ctrlStrobeT           ctrlStb,
  output dpStrobeT             dpStb
);
  localparam int NFLAG   = 2 * NUM_RAILS;
  localparam int STAB_W  = $clog2(STABLE_CYCLES + 1);
  localparam int CNT_MAX = (NMI_MS > STATUS_MS) ? NMI_MS : STATUS_MS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int FAIL_W  = $clog2(FAIL_MS + 1);

  logic [NFLAG-1:0] rawAll;
  logic [NFLAG-1:0] filtQ;
  assign rawAll = {critRaw, warnRaw};

  // per-flag synchroniser and stability filter
  for (genvar g = 0; g < NFLAG; g++) begin : gFlag
    logic [SYNC_STAGES-1:0] syncQ;
    logic [STAB_W-1:0]      stabCnt;
    logic                   filtBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        stabCnt <= '0;
        filtBit <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawAll[g]};
        if (syncQ[SYNC_STAGES-1] != filtBit) begin
          if (stabCnt == STAB_W'(STABLE_CYCLES - 1)) begin
            filtBit <= syncQ[SYNC_STAGES-1];
            stabCnt <= '0;
          end else begin
            stabCnt <= stabCnt + 1'b1;
          end
        end else begin
          stabCnt <= '0;
        end
      end
    end
    assign filtQ[g] = filtBit;
  end

  logic anyCrit, copeCond, tickOk;
  assign anyCrit  = |filtQ[NFLAG-1:NUM_RAILS];
  assign copeCond = (|filtQ[NUM_RAILS-1:0]) | anyCrit;
  assign tickOk   = msTick & ~ctrlStb.freeze;

  logic [CNT_W-1:0]  copeCnt;
  logic [FAIL_W-1:0] critCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copeCnt <= '0;
      critCnt <= '0;
    end else begin
      if (!copeCond)
        copeCnt <= '0;
      else if (tickOk && copeCnt != CNT_W'(CNT_MAX))
        copeCnt <= copeCnt + 1'b1;
      if (!anyCrit)
        critCnt <= '0;
      else if (tickOk && critCnt != FAIL_W'(FAIL_MS))
        critCnt <= critCnt + 1'b1;
    end
  end

  assign dpStb.copeCond = copeCond;
  assign dpStb.nmiHit   = tickOk & copeCond & (copeCnt == CNT_W'(NMI_MS - 1));
  assign dpStb.statHit  = tickOk & copeCond & (copeCnt == CNT_W'(STATUS_MS - 1));
  assign dpStb.failHit  = tickOk & anyCrit & (critCnt == FAIL_W'(FAIL_MS - 1));

  AST_COPE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    copeCnt <= CNT_W'(CNT_MAX)); // R3
  AST_COPE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !copeCond |=> copeCnt == '0); // R3
  AST_CRIT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !anyCrit |=> critCnt == '0); // R6
endmodule

// File: rtl/shmCtrl.sv
module shmCtrl
  import shm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobeT   dpStb,
  input  logic       statusClr,
  output ctrlStrobeT ctrlStb,
  output logic [1:0] healthState,
  output logic       nmiPulse,
  output logic       funcStatus,
  output logic       convEnA,
  output logic       convEnB
);
  healthE stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= HS_NORMAL;
      nmiPulse <= 1'b0;
      convEnA  <= 1'b1;
      convEnB  <= 1'b1;
    end else begin
      nmiPulse <= 1'b0;
      if (stateQ != HS_FAILED) begin
        nmiPulse <= dpStb.nmiHit;
        if (dpStb.failHit) begin
          stateQ  <= HS_FAILED;
          convEnA <= 1'b0;
          convEnB <= 1'b0;
        end else begin
          stateQ <= dpStb.copeCond ? HS_COPING : HS_NORMAL;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      funcStatus <= 1'b0;
    else if (dpStb.statHit)
      funcStatus <= 1'b1;
    else if (statusClr)
      funcStatus <= 1'b0;
  end

  assign ctrlStb.freeze = (stateQ == HS_FAILED);
  assign healthState    = stateQ;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    healthState != 2'b11); // R2
  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> !nmiPulse); // R4
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    dpStb.statHit |=> funcStatus); // R5
  AST_CONV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    healthState == 2'b10 |-> !convEnA && !convEnB); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    healthState == 2'b10 |=> healthState == 2'b10 && !nmiPulse); // R8
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !convEnB |=> !convEnB); // R8
endmodule

// File: rtl/supplyHealthMon.sv
module supplyHealthMon
  import shm_pkg::*;
#(
  parameter int NUM_RAILS     = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 4,
  parameter int NMI_MS        = 100,
  parameter int STATUS_MS     = 500,
  parameter int FAIL_MS       = 100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_RAILS-1:0] lowWarnRaw,
  input  logic [NUM_RAILS-1:0] lowCritRaw,
  input  logic                 msTick,
  input  logic                 statusClr,
  output logic [1:0]           healthState,
  output logic                 nmiPulse,
  output logic                 funcStatus,
  output logic                 convEnA,
  output logic                 convEnB
);
  dpStrobeT   dpStb;
  ctrlStrobeT ctrlStb;

  shmDatapath #(
    .NUM_RAILS(NUM_RAILS), .SYNC_STAGES(SYNC_STAGES), .STABLE_CYCLES(STABLE_CYCLES),
    .NMI_MS(NMI_MS), .STATUS_MS(STATUS_MS), .FAIL_MS(FAIL_MS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .warnRaw(lowWarnRaw), .critRaw(lowCritRaw),
    .msTick(msTick), .ctrlStb(ctrlStb), .dpStb(dpStb)
  );

  shmCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .statusClr(statusClr),
    .ctrlStb(ctrlStb), .healthState(healthState), .nmiPulse(nmiPulse),
    .funcStatus(funcStatus), .convEnA(convEnA), .convEnB(convEnB)
  );
endmodule

// File: tb/supplyHealthMon_tb_top.sv
module supplyHealthMon_tb_top;
  localparam int NR = 3, NMI = 3, STAT = 7, FAIL = 4;
  localparam int CMAX = (NMI > STAT) ? NMI : STAT;

  logic clk = 1'b0, rstN = 1'b0, msTick = 1'b0, statusClr = 1'b0;
  logic [NR-1:0] warnRaw = '0, critRaw = '0;
  logic [1:0] healthState;
  logic nmiPulse, funcStatus, convEnA, convEnB;

  int checks = 0, fails = 0;
  bit done = 0;
  int mCope = 0, mCrit = 0;
  bit mFailed = 0, mStat = 0;

  always #2 clk = ~clk;

  supplyHealthMon #(.NUM_RAILS(NR), .SYNC_STAGES(2), .STABLE_CYCLES(4),
    .NMI_MS(NMI), .STATUS_MS(STAT), .FAIL_MS(FAIL)) dut_i (
    .clk(clk), .rstN(rstN), .lowWarnRaw(warnRaw), .lowCritRaw(critRaw),
    .msTick(msTick), .statusClr(statusClr), .healthState(healthState),
    .nmiPulse(nmiPulse), .funcStatus(funcStatus), .convEnA(convEnA), .convEnB(convEnB));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected nmi for this tick; updates model counters from requirements
  function automatic bit modelTick(input bit cond, input bit crit);
    bit nmiExp = 0;
    if (!mFailed) begin
      if (cond) begin
        if (mCope < CMAX) begin
          mCope++;
          if (mCope == NMI) nmiExp = 1;
          if (mCope == STAT) mStat = 1;
        end
      end else mCope = 0;
      if (crit) begin
        if (mCrit < FAIL) begin
          mCrit++;
          if (mCrit == FAIL) mFailed = 1;
        end
      end else mCrit = 0;
    end
    return nmiExp;
  endfunction

  // one 16-clock tick interval: tick, check, apply new flags, optional glitch/clear
  task automatic tickStep(input logic [NR-1:0] nw, input logic [NR-1:0] nc,
                          input bit glitch, input bit clr);
    bit cond, expNmi;
    int expState;
    cond = (|warnRaw) || (|critRaw);
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
    expNmi = modelTick(cond, |critRaw);
    expState = mFailed ? 2 : (cond ? 1 : 0);
    check(healthState == 2'(expState), "R1 R2 R6 state", healthState, expState);
    check(nmiPulse == expNmi, "R3 R4 nmi", nmiPulse, expNmi);
    check(funcStatus == mStat, "R5 status", funcStatus, mStat);
    check(convEnA == !mFailed && convEnB == !mFailed, "R7 R8 enables",
          {convEnA, convEnB}, mFailed ? 0 : 3);
    @(negedge clk);
    check(nmiPulse == 1'b0, "R4 single cycle", nmiPulse, 0);
    warnRaw = nw;
    critRaw = nc;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (glitch && i == 2) begin
        if (warnRaw == '0) warnRaw[$urandom_range(NR-1)] = 1'b1;
        else critRaw[$urandom_range(NR-1)] = ~critRaw[0];
      end
      if (glitch && i == 4) begin warnRaw = nw; critRaw = nc; end
      if (clr && i == 9) statusClr = 1'b1;
      if (clr && i == 10) begin statusClr = 1'b0; mStat = 0; end
    end
  endtask

  function automatic logic [NR-1:0] rndFlags(input int oneIn);
    logic [NR-1:0] v;
    for (int b = 0; b < NR; b++) v[b] = ($urandom_range(oneIn - 1) == 0);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [NR-1:0] w, c;
    void'($urandom(32'd24681357));
    repeat (5) @(negedge clk);
    // R9 reset values
    check(healthState == 2'b00, "R9 reset state", healthState, 0);
    check(nmiPulse == 0 && funcStatus == 0, "R9 reset nmi/status", {nmiPulse, funcStatus}, 0);
    check(convEnA && convEnB, "R9 reset enables", {convEnA, convEnB}, 3);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 glitches only: nothing must move
    for (int k = 0; k < 6; k++) tickStep('0, '0, 1'b1, 1'b0);
    // R3 broken episodes: two ticks, gap, two ticks -> no nmi
    tickStep(3'b001, '0, 0, 0);
    tickStep(3'b001, '0, 0, 0);
    tickStep('0, '0, 0, 0);
    tickStep(3'b100, '0, 0, 0);
    tickStep(3'b100, '0, 0, 0);
    // R4 R5 long episode, then clear status
    for (int k = 0; k < 10; k++) tickStep(3'b010, '0, 0, 0);
    tickStep('0, '0, 0, 1'b1);
    tickStep('0, '0, 0, 0);
    // R6 critical episode broken just before the limit
    for (int k = 0; k < FAIL - 1; k++) tickStep('0, 3'b001, 0, 0);
    tickStep('0, '0, 0, 0);
    tickStep('0, '0, 0, 0);
    // random, warn flags only
    w = '0; c = '0;
    for (int k = 0; k < 150; k++) begin
      if ($urandom_range(3) == 0) w = rndFlags(4);
      tickStep(w, c, $urandom_range(4) == 0, $urandom_range(5) == 0);
    end
    // random with critical flags until failure
    for (int k = 0; k < 200 && !mFailed; k++) begin
      if ($urandom_range(3) == 0) w = rndFlags(4);
      if ($urandom_range(2) == 0) c = rndFlags(5);
      tickStep(w, c, $urandom_range(4) == 0, $urandom_range(5) == 0);
    end
    for (int k = 0; k < FAIL + 1 && !mFailed; k++) tickStep(w, 3'b010, 0, 0);
    // R8 frozen after failure
    for (int k = 0; k < 30; k++)
      tickStep(rndFlags(2), rndFlags(3), $urandom_range(3) == 0, $urandom_range(4) == 0);
    tickStep('0, '0, 0, 0);
    check(mFailed, "R6 failure reached", mFailed, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule